// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers seven peripheral interrupt request flags, qualifies them with an 8-bit enable byte, and presents a single request to the processor. The request carries the 16-bit entry address of the source that wins. There is one priority level only. Once the processor accepts a request, that source is in service and nothing else is offered until the processor signals a return. A fixed order, with no priority register, settles requests that are pending at the same time.

The request/vector pair acts as the valid side of a handshake, and the acknowledge strobe acts as the accepting side. The processor can hold off the acknowledge for as long as it likes. While it waits, every flag stays pending and the offered vector always follows the current highest eligible source. The winner is fixed only in the cycle where the request and the acknowledge are high together. Some sources are edge-type. For an accepted edge-type source the controller sends a one-cycle clear pulse back to that source's flag. Level-type sources must drop their own requests.

Source index order, highest priority first: 0 external line A, 1 timer overflow, 2 external line B, 3 PWM overflow, 4 watchdog timer, 5 serial bus, 6 A/D done.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the enable byte is 0x00, `irq_o` is low, `vector_o` is 0x0000 and `flag_clr_o` is 0, whatever the request lines carry.
- R2: A source is eligible only when its request bit, its own enable bit and the global enable bit are all 1.
- R3: When enable bit 7 (global) is 0, `irq_o` stays low for any request pattern and any other enable bits.
- R4: Among eligible sources the lowest index wins: external A, timer, external B, PWM, watchdog, serial bus, A/D.
- R5: While `irq_o` is high, `vector_o` holds the winner's entry address: external A 0x0003, timer 0x000B, external B 0x0013, watchdog 0x001B, serial bus 0x0023, A/D 0x002B, PWM 0x0033. While `irq_o` is low it reads 0x0000.
- R6: The individual enable bits are laid out as follows: bit 0 external A, bit 1 timer, bit 2 external B, bit 3 PWM, bit 4 serial bus, bit 5 watchdog, bit 6 A/D.
- R7: An acknowledge taken while `irq_o` is high puts the controller in service from the next cycle. `irq_o` then stays low until a cycle after `reti_i`, and flags that are still pending are offered again from that cycle.
- R8: In the cycle after an accepted acknowledge, `flag_clr_o` carries a single one-cycle pulse on the winner's bit if that source is edge-type. The default `EDGE_MASK` 7'b0000101 makes external A and external B edge-type. Level-type winners give no pulse.
- R9: An acknowledge while `irq_o` is low, and a return strobe while nothing is in service, have no effect.
- R10: A write to the enable byte takes effect on `irq_o` in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 7 | Request flags, index in priority order |
| ie_wr_i | input | 1 | Enable byte write strobe |
| ie_wdata_i | input | 8 | Enable byte write data |
| ack_i | input | 1 | Processor accepts the offered request |
| reti_i | input | 1 | Processor returns from the service routine |
| irq_o | output | 1 | Request to the processor (valid) |
| vector_o | output | 16 | Entry address of the winning source |
| flag_clr_o | output | 7 | One-cycle clear pulses for edge-type flags |

## Verification
On every cycle, assertions check the following: the global bit blocks all requests, no request appears while a source is in service, the vector is one of the seven legal addresses, the winner has no higher eligible source, and each clear pulse is one-hot and follows an accepted acknowledge. Only the bench scenarios can show that the enable bits map to the right sources, that every source gets its exact address, and that ordering holds under stacked request patterns. The same goes for the exact cycle where a write, an acknowledge or a return becomes visible, and for the difference between edge-type and level-type sources.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC    = 7;
  localparam int IE_W    = 8;
  localparam int GLB_BIT = 7;
  localparam int ID_W    = $clog2(NSRC);

  typedef enum logic [ID_W-1:0] {
    SRC_XA   = 3'd0,
    SRC_TMR  = 3'd1,
    SRC_XB   = 3'd2,
    SRC_PWM  = 3'd3,
    SRC_WDT  = 3'd4,
    SRC_SBUS = 3'd5,
    SRC_ADC  = 3'd6
  } src_e;

  // enable-byte bit that belongs to a priority index
  function automatic int unsigned en_bit_of(input int unsigned p);
    case (p)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 5;
      5: return 4;
      6: return 6;
      default: return 0;
    endcase
  endfunction

  // position in the vector table for a priority index
  function automatic int unsigned vec_slot_of(input int unsigned p);
    case (p)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 6;
      4: return 3;
      5: return 4;
      6: return 5;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/intc_enable_reg.sv
module intc_enable_reg
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [IE_W-1:0] wdata,
  output logic            glb_en,
  output logic [NSRC-1:0] src_en
);
  logic [IE_W-1:0] ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  ie_q <= '0;
    else if (wr) ie_q <= wdata;
  end

  assign glb_en = ie_q[GLB_BIT];

  for (genvar g = 0; g < NSRC; g++) begin : g_map
    assign src_en[g] = ie_q[en_bit_of(g)];
  end

  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ie_q == $past(wdata)));
  a_r1_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ie_q));
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
  import intc_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  src_en,
  input  logic             glb_en,
  output logic             any,
  output logic [ID_W-1:0]  win_id,
  output logic [VEC_W-1:0] win_vec
);
  logic [NSRC-1:0] elig;
  assign elig = req & src_en & {NSRC{glb_en}};
  assign any  = |elig;

  always_comb begin
    win_id = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) win_id = ID_W'(i);
    end
  end

  always_comb begin
    win_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (win_id == ID_W'(i))
        win_vec = VEC_W'(VEC_BASE + VEC_STRIDE * vec_slot_of(i));
    end
  end

  // no eligible source ranks above the chosen one
  a_r4_none_above: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((elig & ((NSRC'(1) << win_id) - NSRC'(1))) == '0));
  a_r2_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[win_id] && src_en[win_id] && glb_en));
endmodule

// File: rtl/intc_svc_ctrl.sv
module intc_svc_ctrl
  import intc_pkg::*;
#(
  parameter logic [NSRC-1:0] EDGE_MASK = 7'b0000101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any,
  input  logic [ID_W-1:0] win_id,
  input  logic            ack,
  input  logic            reti,
  output logic            busy,
  output logic [NSRC-1:0] clr
);
  logic take;
  assign take = ack && any && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      clr  <= '0;
    end else begin
      clr <= '0;
      if (take) begin
        busy <= 1'b1;
        clr  <= EDGE_MASK & (NSRC'(1) << win_id);
      end else if (reti) begin
        busy <= 1'b0;
      end
    end
  end

  a_r8_clr_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |-> $past(take));
  a_r8_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
  a_r7_busy_until_reti: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !reti) |=> busy);
  a_r9_idle_reti_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> !busy);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int               VEC_W      = 16,
  parameter int               VEC_BASE   = 3,
  parameter int               VEC_STRIDE = 8,
  parameter logic [NSRC-1:0]  EDGE_MASK  = 7'b0000101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       req_i,
  input  logic             ie_wr_i,
  input  logic [7:0]       ie_wdata_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [6:0]       flag_clr_o
);
  logic            glb_en;
  logic [NSRC-1:0] src_en;
  logic            any;
  logic [ID_W-1:0] win_id;
  logic [VEC_W-1:0] win_vec;
  logic            busy;

  intc_enable_reg u_ie (
    .clk(clk), .rst_n(rst_n), .wr(ie_wr_i), .wdata(ie_wdata_i),
    .glb_en(glb_en), .src_en(src_en)
  );

  intc_prio_arb #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_i), .src_en(src_en), .glb_en(glb_en),
    .any(any), .win_id(win_id), .win_vec(win_vec)
  );

  intc_svc_ctrl #(.EDGE_MASK(EDGE_MASK)) u_svc (
    .clk(clk), .rst_n(rst_n), .any(any), .win_id(win_id), .ack(ack_i),
    .reti(reti_i), .busy(busy), .clr(flag_clr_o)
  );

  assign irq_o    = any && !busy;
  assign vector_o = irq_o ? win_vec : '0;

  a_r3_global_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_o);
  a_r7_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_o);
  a_r5_legal_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((vector_o >= VEC_W'(VEC_BASE)) &&
               (vector_o <= VEC_W'(VEC_BASE + VEC_STRIDE * (NSRC - 1))) &&
               (((vector_o - VEC_W'(VEC_BASE)) % VEC_W'(VEC_STRIDE)) == '0)));
  a_r5_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vector_o == '0));
endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  req_i = '0;
  logic        ie_wr_i = 1'b0;
  logic [7:0]  ie_wdata_i = '0;
  logic        ack_i = 1'b0;
  logic        reti_i = 1'b0;
  logic        irq_o;
  logic [15:0] vector_o;
  logic [6:0]  flag_clr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ie_wr_i(ie_wr_i),
    .ie_wdata_i(ie_wdata_i), .ack_i(ack_i), .reti_i(reti_i),
    .irq_o(irq_o), .vector_o(vector_o), .flag_clr_o(flag_clr_o)
  );

  // {enable byte, request, expected irq, expected vector}
  localparam int NV = 16;
  localparam logic [31:0] TBL [NV] = '{
    {8'h00, 7'h7F, 1'b0, 16'h0000},  // R3 nothing enabled
    {8'h7F, 7'h7F, 1'b0, 16'h0000},  // R3 global off
    {8'hFF, 7'h7F, 1'b1, 16'h0003},  // R4 ext A on top
    {8'hFF, 7'h7E, 1'b1, 16'h000B},  // R4 timer
    {8'hFF, 7'h7C, 1'b1, 16'h0013},  // R4 ext B
    {8'hFF, 7'h78, 1'b1, 16'h0033},  // R4 PWM
    {8'hFF, 7'h70, 1'b1, 16'h001B},  // R4 watchdog
    {8'hFF, 7'h60, 1'b1, 16'h0023},  // R4 serial
    {8'hFF, 7'h40, 1'b1, 16'h002B},  // R4 A/D
    {8'h81, 7'h7E, 1'b0, 16'h0000},  // R2 enabled source not requesting
    {8'hA0, 7'h7F, 1'b1, 16'h001B},  // R6 bit5 -> watchdog
    {8'h90, 7'h7F, 1'b1, 16'h0023},  // R6 bit4 -> serial
    {8'h88, 7'h7F, 1'b1, 16'h0033},  // R6 bit3 -> PWM
    {8'hC0, 7'h7F, 1'b1, 16'h002B},  // R6 bit6 -> A/D
    {8'h82, 7'h7D, 1'b0, 16'h0000},  // R2 timer enabled, not requesting
    {8'hFF, 7'h00, 1'b0, 16'h0000}   // R2 no request
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr_ie(input logic [7:0] v);
    @(negedge clk); ie_wr_i = 1'b1; ie_wdata_i = v;
    @(negedge clk); ie_wr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req_i = 7'h7F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 vector", 32'(vector_o), 0);
    chk("R1 clr", 32'(flag_clr_o), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); ie_wr_i = 1'b1; ie_wdata_i = TBL[i][31:24]; req_i = TBL[i][23:17];
      @(negedge clk); ie_wr_i = 1'b0;
      #1;
      chk($sformatf("R2/R3/R4/R6 row%0d irq", i), 32'(irq_o), 32'(TBL[i][16]));
      chk($sformatf("R5 row%0d vector", i), 32'(vector_o), 32'(TBL[i][15:0]));
    end

    // R10: write visible only after the strobe's edge
    wr_ie(8'h00);
    req_i = 7'h7F;
    @(negedge clk); ie_wr_i = 1'b1; ie_wdata_i = 8'hFF; #1;
    chk("R10 before edge", 32'(irq_o), 0);
    @(negedge clk); ie_wr_i = 1'b0; #1;
    chk("R10 after edge", 32'(irq_o), 1);
    chk("R10 vector", 32'(vector_o), 32'h0003);

    // R7 / R8 service cycle with edge-type ext A
    @(negedge clk); req_i = 7'h05; ack_i = 1'b1; #1;
    chk("R7 offered before ack", 32'(irq_o), 1);
    @(negedge clk); ack_i = 1'b0; #1;
    chk("R7 irq drops in service", 32'(irq_o), 0);
    chk("R8 clr ext A", 32'(flag_clr_o), 32'h01);
    req_i = 7'h04;
    @(negedge clk); #1;
    chk("R8 pulse one cycle", 32'(flag_clr_o), 0);
    chk("R7 pending held", 32'(irq_o), 0);
    @(negedge clk); reti_i = 1'b1; #1;
    chk("R7 still held at reti", 32'(irq_o), 0);
    @(negedge clk); reti_i = 1'b0; #1;
    chk("R7 reoffer after reti", 32'(irq_o), 1);
    chk("R7 reoffer vector", 32'(vector_o), 32'h0013);
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; #1;
    chk("R8 clr ext B", 32'(flag_clr_o), 32'h04);
    req_i = 7'h02;
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0; #1;
    chk("R7 timer offered", 32'(vector_o), 32'h000B);
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; #1;
    chk("R8 level no clr", 32'(flag_clr_o), 0);
    chk("R7 timer in service", 32'(irq_o), 0);
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0;

    // R9: stray ack and stray reti
    wr_ie(8'h00);
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; #1;
    chk("R9 stray ack no clr", 32'(flag_clr_o), 0);
    wr_ie(8'hFF);
    #1;
    chk("R9 stray ack ignored", 32'(irq_o), 1);
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0; #1;
    chk("R9 stray reti ignored", 32'(irq_o), 1);
    chk("R9 vector kept", 32'(vector_o), 32'h000B);

    // R1: reset mid-service clears everything
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 reset irq", 32'(irq_o), 0);
    chk("R1 reset clr", 32'(flag_clr_o), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule